// File: doc/BRIEF.md
# Line Uniformity Statistics Engine

This block measures how evenly a linear image sensor line responds. It takes one line of digitised samples from a scanner front end. The samples are framed by a line-start strobe and a line-end strobe, and each one is qualified by a valid strobe. When the line ends, the block works out four figures: the average level, the largest distance of any pixel from that average, that distance as a percentage of the average, and the odd-versus-even imbalance as a percentage of the average.

Accumulation runs at one sample per clock. A single restoring divider then produces the three quotients one after another. The results are loaded together into an output register set, and a done flag is raised at the same moment. If the line does not carry exactly the configured number of samples, an error flag is raised instead and the previous results are left untouched. A calibration controller pulses the line start, streams the line, and reads the figures once done or the error flag appears.

Top module: `line_uniformity_stats`

## Requirements
- R1: After reset, `done` and `err` are 0 and every result output is 0.
- R2: `avg_level` is floor(S / PIX_COUNT). S is the sum of every sample with `pix_vld` high from the cycle after an accepted `line_start` up to and including the `line_end` cycle.
- R3: `peak_dev` is the largest |x - avg_level| over the samples of the line. `avg_level` here is the floored mean from R2.
- R4: `prnu_pct` is floor(peak_dev * 100 * 2^FRAC / avg_level). It is a percentage with FRAC fraction bits.
- R5: Samples are numbered from 1 in arrival order. D is the sum of the odd-numbered samples minus the sum of the even-numbered ones. `imbal_pct` is floor(200 * |D| * 2^FRAC / (PIX_COUNT * avg_level)). `imbal_neg` is 1 exactly when D < 0.
- R6: If the number of counted samples differs from PIX_COUNT at line end, `err` rises, `done` stays 0, and all result outputs keep their previous values.
- R7: A `line_start` is accepted only when the block is idle. A `line_start` that arrives while a line is being collected or its figures are being computed has no effect.
- R8: `done` and `err` hold their value until the next accepted `line_start`, which clears both on the following clock edge.
- R9: When `avg_level` is 0, `prnu_pct` and `imbal_pct` are all ones.
- R10: Samples with `pix_vld` high while the block is idle are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Begin a new line (accepted when idle) |
| pix_vld | input | 1 | Sample on `pix_data` is valid |
| pix_data | input | DW | Digitised pixel sample |
| line_end | input | 1 | Last cycle of the line |
| done | output | 1 | Results valid for the last line |
| err | output | 1 | Last line had the wrong sample count |
| avg_level | output | DW | Floored mean level |
| peak_dev | output | DW | Largest deviation from the mean |
| prnu_pct | output | DW+7+FRAC | Peak deviation as a percentage of the mean |
| imbal_pct | output | DW+7+FRAC | Odd/even imbalance as a percentage of the mean |
| imbal_neg | output | 1 | Even samples outweigh odd samples |

## Verification
The bench runs five kinds of line, and each separates a different part of the arithmetic:
- A ramp gives a non-trivial mean and a peak deviation that lies on the low side.
- A flat line must give zero for every deviation figure.
- Two alternating lines, odd-high and even-high, produce the same imbalance magnitude with opposite signs, so any error in the sign handling shows up.
- An all-zero line exercises the divide-by-zero saturation.

Lines one sample short and one sample long check the count guard. Stray strobes, sent while a line is collecting, while figures are computing, and while the block is idle, show whether control state or accumulation leaks across line boundaries.

// File: rtl/line_unif_pkg.sv
package line_unif_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_CHECK,
        ST_DIV_GO,
        ST_DIV_WAIT
    } ctl_state_t;

    typedef enum logic [1:0] {
        PH_MEAN,
        PH_PRNU,
        PH_IMB
    } div_phase_t;

    localparam int PCT_SCALE = 100;
    localparam int IMB_SCALE = 200;

    function automatic int sum_width(input int dw, input int n);
        return dw + $clog2(n + 1);
    endfunction

    function automatic int count_width(input int n);
        return $clog2(n + 2);
    endfunction

endpackage

// File: rtl/line_unif_accum.sv
module line_unif_accum
    import line_unif_pkg::*;
#(
    parameter int DW        = 12,
    parameter int PIX_COUNT = 10800,
    parameter int SUMW      = sum_width(DW, PIX_COUNT),
    parameter int CNTW      = count_width(PIX_COUNT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            en,
    input  logic            vld,
    input  logic [DW-1:0]   data,
    output logic [CNTW-1:0] cnt,
    output logic [SUMW-1:0] sum,
    output logic [DW-1:0]   min_o,
    output logic [DW-1:0]   max_o,
    output logic [SUMW:0]   diff_o
);

    localparam logic [CNTW-1:0] CNT_LIM = CNTW'(PIX_COUNT + 1);

    logic          even_next;
    logic [SUMW:0] ext;

    assign ext = (SUMW + 1)'(data);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt       <= '0;
            sum       <= '0;
            min_o     <= '1;
            max_o     <= '0;
            diff_o    <= '0;
            even_next <= 1'b0;
        end else if (en && vld) begin
            if (cnt != CNT_LIM) begin
                cnt <= cnt + 1'b1;
            end
            sum <= sum + SUMW'(data);
            if (data < min_o) begin
                min_o <= data;
            end
            if (data > max_o) begin
                max_o <= data;
            end
            diff_o    <= even_next ? (diff_o - ext) : (diff_o + ext);
            even_next <= ~even_next;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LIM); // R6
    AST_EXTREMA_ORDER: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> (min_o <= max_o)); // R3
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt)); // R10

endmodule

// File: rtl/line_unif_divider.sv
module line_unif_divider #(
    parameter int DVW = 32,
    parameter int DSW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [DVW-1:0] dividend,
    input  logic [DSW-1:0] divisor,
    output logic           busy,
    output logic           fin,
    output logic [DVW-1:0] quot
);

    localparam int CW = $clog2(DVW + 1);

    logic [DVW-1:0] work;
    logic [DSW-1:0] dsr;
    logic [DSW:0]   rem;
    logic [DSW:0]   rem_sh;
    logic [DSW:0]   rem_nx;
    logic           qbit;
    logic [CW-1:0]  left;

    always_comb begin
        rem_sh = {rem[DSW-1:0], work[DVW-1]};
        qbit   = (rem_sh >= {1'b0, dsr});
        rem_nx = qbit ? (rem_sh - {1'b0, dsr}) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= '0;
            dsr  <= '0;
            rem  <= '0;
            left <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                work <= dividend;
                dsr  <= divisor;
                rem  <= '0;
                left <= CW'(DVW);
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= rem_nx;
                work <= {work[DVW-2:0], qbit};
                left <= left - 1'b1;
                if (left == CW'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    assign quot = work;

    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R2
    AST_DIV_FIN_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        fin |-> !busy); // R4

endmodule

// File: rtl/line_uniformity_stats.sv
module line_uniformity_stats
    import line_unif_pkg::*;
#(
    parameter int PIX_COUNT = 10800,
    parameter int DW        = 12,
    parameter int FRAC      = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_start,
    input  logic                 pix_vld,
    input  logic [DW-1:0]        pix_data,
    input  logic                 line_end,
    output logic                 done,
    output logic                 err,
    output logic [DW-1:0]        avg_level,
    output logic [DW-1:0]        peak_dev,
    output logic [DW+7+FRAC-1:0] prnu_pct,
    output logic [DW+7+FRAC-1:0] imbal_pct,
    output logic                 imbal_neg
);

    localparam int SUMW = sum_width(DW, PIX_COUNT);
    localparam int CNTW = count_width(PIX_COUNT);
    localparam int DVW  = SUMW + 8 + FRAC;
    localparam int DSW  = SUMW;
    localparam int PW   = DW + 7 + FRAC;

    localparam logic [CNTW-1:0] CNT_GOOD = CNTW'(PIX_COUNT);
    localparam logic [DSW-1:0]  N_DSR    = DSW'(PIX_COUNT);
    localparam logic [DVW-1:0]  K_PCT    = DVW'(PCT_SCALE);
    localparam logic [DVW-1:0]  K_IMB    = DVW'(IMB_SCALE);

    typedef struct packed {
        logic [DW-1:0] avg;
        logic [DW-1:0] peak;
        logic [PW-1:0] prnu;
        logic [PW-1:0] imb;
        logic          neg;
    } result_t;

    ctl_state_t state;
    div_phase_t phase;
    result_t    res_q;

    logic            acc_clr;
    logic            acc_en;
    logic [CNTW-1:0] cnt;
    logic [SUMW-1:0] sum;
    logic [DW-1:0]   minv;
    logic [DW-1:0]   maxv;
    logic [SUMW:0]   diff;
    logic [SUMW:0]   absd;

    logic            div_start;
    logic            div_busy;
    logic            div_fin;
    logic [DVW-1:0]  div_dvd;
    logic [DSW-1:0]  div_dsr;
    logic [DVW-1:0]  div_q;

    logic [DW-1:0]   mean_w;
    logic [DW-1:0]   dev_w;
    logic [PW-1:0]   prnu_w;
    logic [DW-1:0]   q_mean;
    logic [DW-1:0]   dev_up;
    logic [DW-1:0]   dev_dn;
    logic [DW-1:0]   dev_calc;
    logic            done_q;
    logic            err_q;

    assign acc_clr   = (state == ST_IDLE) && line_start;
    assign acc_en    = (state == ST_COLLECT);
    assign div_start = (state == ST_DIV_GO);

    line_unif_accum #(
        .DW(DW), .PIX_COUNT(PIX_COUNT), .SUMW(SUMW), .CNTW(CNTW)
    ) u_accum (
        .clk(clk), .rst(rst), .clr(acc_clr), .en(acc_en),
        .vld(pix_vld), .data(pix_data),
        .cnt(cnt), .sum(sum), .min_o(minv), .max_o(maxv), .diff_o(diff)
    );

    line_unif_divider #(
        .DVW(DVW), .DSW(DSW)
    ) u_div (
        .clk(clk), .rst(rst), .start(div_start),
        .dividend(div_dvd), .divisor(div_dsr),
        .busy(div_busy), .fin(div_fin), .quot(div_q)
    );

    always_comb begin
        absd = diff[SUMW] ? (~diff + 1'b1) : diff;
    end

    always_comb begin
        q_mean   = div_q[DW-1:0];
        dev_up   = maxv - q_mean;
        dev_dn   = q_mean - minv;
        dev_calc = (dev_up > dev_dn) ? dev_up : dev_dn;
    end

    always_comb begin
        case (phase)
            PH_MEAN: begin
                div_dvd = DVW'(sum);
                div_dsr = N_DSR;
            end
            PH_PRNU: begin
                div_dvd = (DVW'(dev_w) * K_PCT) << FRAC;
                div_dsr = DSW'(mean_w);
            end
            PH_IMB: begin
                div_dvd = (DVW'(absd) * K_IMB) << FRAC;
                div_dsr = N_DSR * DSW'(mean_w);
            end
            default: begin
                div_dvd = '0;
                div_dsr = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            phase  <= PH_MEAN;
            mean_w <= '0;
            dev_w  <= '0;
            prnu_w <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (line_start) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                        state  <= ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    if (line_end) begin
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (cnt == CNT_GOOD) begin
                        phase <= PH_MEAN;
                        state <= ST_DIV_GO;
                    end else begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_DIV_GO: begin
                    state <= ST_DIV_WAIT;
                end
                ST_DIV_WAIT: begin
                    if (div_fin) begin
                        case (phase)
                            PH_MEAN: begin
                                mean_w <= q_mean;
                                dev_w  <= dev_calc;
                                phase  <= PH_PRNU;
                                state  <= ST_DIV_GO;
                            end
                            PH_PRNU: begin
                                prnu_w <= div_q[PW-1:0];
                                phase  <= PH_IMB;
                                state  <= ST_DIV_GO;
                            end
                            default: begin
                                res_q.avg  <= mean_w;
                                res_q.peak <= dev_w;
                                res_q.prnu <= prnu_w;
                                res_q.imb  <= div_q[PW-1:0];
                                res_q.neg  <= diff[SUMW];
                                done_q     <= 1'b1;
                                state      <= ST_IDLE;
                            end
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done      = done_q;
    assign err       = err_q;
    assign avg_level = res_q.avg;
    assign peak_dev  = res_q.peak;
    assign prnu_pct  = res_q.prnu;
    assign imbal_pct = res_q.imb;
    assign imbal_neg = res_q.neg;

    AST_MEAN_FITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIV_WAIT && div_fin && phase == PH_MEAN)
            |-> (div_q[DVW-1:DW] == '0)); // R2
    AST_PRNU_FITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIV_WAIT && div_fin && phase == PH_PRNU && mean_w != '0)
            |-> (div_q[DVW-1:PW] == '0)); // R4
    AST_MEAN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        done |-> (avg_level >= minv && avg_level <= maxv)); // R2
    AST_DEV_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        done |-> (peak_dev <= maxv - minv)); // R3
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !(state == ST_IDLE && line_start)) |=> done); // R8
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (err && !(state == ST_IDLE && line_start)) |=> err); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_COLLECT && line_start)
            |=> (state != ST_COLLECT)); // R7
    AST_RESULTS_KEPT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $stable(avg_level) && $stable(prnu_pct)); // R6

endmodule

// File: tb/line_uniformity_stats_test.sv
module line_uniformity_stats_test;

    localparam int NPIX = 12;
    localparam int DW   = 8;
    localparam int FRAC = 4;
    localparam int PW   = DW + 7 + FRAC;
    localparam longint PW_ONES = (64'd1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          line_start;
    logic          pix_vld;
    logic [DW-1:0] pix_data;
    logic          line_end;
    logic          done;
    logic          err;
    logic [DW-1:0] avg_level;
    logic [DW-1:0] peak_dev;
    logic [PW-1:0] prnu_pct;
    logic [PW-1:0] imbal_pct;
    logic          imbal_neg;

    always #5 clk = ~clk;

    line_uniformity_stats #(.PIX_COUNT(NPIX), .DW(DW), .FRAC(FRAC)) uut (
        .clk(clk), .rst(rst), .line_start(line_start), .pix_vld(pix_vld),
        .pix_data(pix_data), .line_end(line_end), .done(done), .err(err),
        .avg_level(avg_level), .peak_dev(peak_dev), .prnu_pct(prnu_pct),
        .imbal_pct(imbal_pct), .imbal_neg(imbal_neg)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int pat [16];
    longint e_avg, e_peak, e_prnu, e_imb, e_neg;
    logic flag_done_at_start, flag_err_at_start;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            summary();
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic calc();
        longint s, mn, mx, d, up, dn;
        s = 0; mn = 1 << DW; mx = -1; d = 0;
        for (int i = 0; i < NPIX; i++) begin
            s += pat[i];
            if (pat[i] < mn) mn = pat[i];
            if (pat[i] > mx) mx = pat[i];
            if (i % 2 == 0) d += pat[i]; else d -= pat[i];
        end
        e_avg  = s / NPIX;
        up     = mx - e_avg;
        dn     = e_avg - mn;
        e_peak = (up > dn) ? up : dn;
        e_neg  = (d < 0) ? 1 : 0;
        if (d < 0) d = -d;
        if (e_avg == 0) begin
            e_prnu = PW_ONES;
            e_imb  = PW_ONES;
        end else begin
            e_prnu = (e_peak * 100 * (1 << FRAC)) / e_avg;
            e_imb  = (d * 200 * (1 << FRAC)) / (NPIX * e_avg);
        end
    endtask

    task automatic send_line(input int n, input bit end_same, input int extra_start_at);
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        flag_done_at_start = done;
        flag_err_at_start  = err;
        for (int i = 0; i < n; i++) begin
            pix_vld    = 1'b1;
            pix_data   = DW'(pat[i]);
            line_start = (i == extra_start_at);
            line_end   = end_same && (i == n - 1);
            @(negedge clk);
        end
        pix_vld    = 1'b0;
        line_start = 1'b0;
        if (!end_same) begin
            line_end = 1'b1;
            @(negedge clk);
        end
        line_end = 1'b0;
    endtask

    task automatic wait_result(input string req);
        int k;
        k = 0;
        while (!(done || err) && k < 2000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 2000) begin
            checks++;
            errors++;
            $display("FAIL %s wait actual=timeout expected=done_or_err", req);
        end
    endtask

    task automatic check_figures(input string req);
        chk(req, "done", done, 1);
        chk(req, "err", err, 0);
        chk(req, "avg_level", avg_level, e_avg);
        chk(req, "peak_dev", peak_dev, e_peak);
        chk(req, "prnu_pct", prnu_pct, e_prnu);
        chk(req, "imbal_pct", imbal_pct, e_imb);
        chk(req, "imbal_neg", imbal_neg, e_neg);
    endtask

    task automatic t_reset();
        chk("R1", "done", done, 0);
        chk("R1", "err", err, 0);
        chk("R1", "avg_level", avg_level, 0);
        chk("R1", "prnu_pct", prnu_pct, 0);
        chk("R1", "imbal_pct", imbal_pct, 0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < 16; i++) pat[i] = 10 + 10 * i;
        pat[0] = 3;
        calc();
        send_line(NPIX, 1'b1, -1);
        wait_result("R2");
        check_figures("R2_R3_R4_R5_ramp");
    endtask

    task automatic t_flat();
        for (int i = 0; i < 16; i++) pat[i] = 50;
        calc();
        send_line(NPIX, 1'b0, -1);
        chk("R8", "done_cleared_by_start", flag_done_at_start, 0);
        wait_result("R3");
        check_figures("R3_flat");
        chk("R3", "flat_peak_zero", peak_dev, 0);
    endtask

    task automatic t_alternate(input bit odd_high);
        for (int i = 0; i < 16; i++)
            pat[i] = ((i % 2 == 0) == odd_high) ? 200 : 100;
        calc();
        send_line(NPIX, 1'b0, -1);
        wait_result("R5");
        check_figures(odd_high ? "R5_odd_high" : "R5_even_high");
    endtask

    task automatic t_bad_count(input int n);
        longint prev_avg, prev_prnu;
        prev_avg  = avg_level;
        prev_prnu = prnu_pct;
        for (int i = 0; i < 16; i++) pat[i] = 30 + i;
        send_line(n, 1'b0, -1);
        wait_result("R6");
        chk("R6", "err", err, 1);
        chk("R6", "done", done, 0);
        chk("R6", "avg_kept", avg_level, prev_avg);
        chk("R6", "prnu_kept", prnu_pct, prev_prnu);
        repeat (5) @(negedge clk);
        chk("R8", "err_held", err, 1);
    endtask

    task automatic t_restart_ignored();
        for (int i = 0; i < 16; i++) pat[i] = (i * 37) % 251;
        calc();
        send_line(NPIX, 1'b0, 6);
        chk("R8", "err_cleared_by_start", flag_err_at_start, 0);
        repeat (4) @(negedge clk);
        line_start = 1'b1;
        pix_vld    = 1'b1;
        pix_data   = 8'd255;
        @(negedge clk);
        line_start = 1'b0;
        repeat (3) @(negedge clk);
        line_end = 1'b1;
        @(negedge clk);
        line_end = 1'b0;
        pix_vld  = 1'b0;
        wait_result("R7");
        check_figures("R7_restart_ignored");
        repeat (40) @(negedge clk);
        chk("R7", "done_still", done, 1);
        chk("R7", "avg_still", avg_level, e_avg);
    endtask

    task automatic t_idle_pixels();
        pix_vld  = 1'b1;
        pix_data = 8'd255;
        repeat (6) @(negedge clk);
        pix_vld = 1'b0;
        chk("R8", "done_held_idle", done, 1);
        for (int i = 0; i < 16; i++) pat[i] = 20 + 3 * i;
        calc();
        send_line(NPIX, 1'b1, -1);
        wait_result("R10");
        check_figures("R10_idle_pixels");
    endtask

    task automatic t_zero();
        for (int i = 0; i < 16; i++) pat[i] = 0;
        calc();
        send_line(NPIX, 1'b0, -1);
        wait_result("R9");
        check_figures("R9_zero_mean");
        chk("R9", "prnu_sat", prnu_pct, PW_ONES);
        chk("R9", "imbal_sat", imbal_pct, PW_ONES);
    endtask

    initial begin
        rst        = 1'b1;
        line_start = 1'b0;
        pix_vld    = 1'b0;
        pix_data   = '0;
        line_end   = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ramp();
        t_flat();
        t_alternate(1'b1);
        t_alternate(1'b0);
        t_bad_count(NPIX - 1);
        t_bad_count(NPIX + 1);
        t_restart_ignored();
        t_idle_pixels();
        t_zero();
        summary();
    end

endmodule